// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block is the processor-facing side of a PC-style keyboard controller. The host reaches it through byte reads and writes to two ports, selected by one input: a data port and a combined command/status port. The block holds a one-byte output buffer with a full flag, an 8-bit configuration byte, and a pending-write state for the two commands that take a data byte. Its outputs are an interrupt request, an address-line-20 gate, and a timed CPU reset pulse.

Bytes from the keyboard side arrive as a load strobe with a data byte. The block raises a hold output whenever it cannot take such a byte, either because the keyboard has been switched off by command or because the buffer still holds unread data. A load that arrives while hold is high is dropped. The host reads the buffer through the data port, and reads the full flag through the status port.

Commands written to the command port do the following:
- Copy the configuration byte into the buffer.
- Route the next data-port write into the configuration byte, or out to the output-port lines.
- Switch the keyboard off or back on.
- In the range 0xF0 to 0xFF, clear the buffer and the pending state, and for even codes start a reset pulse whose length in clock cycles is a parameter.

Top module: `kbc_host_if`

## Requirements
- R1: After synchronous reset the buffer is empty, irq, a20_gate, cpu_reset and kbd_hold are 0, and the configuration byte is 0x01.
- R2: A read with host_port_cmd=1 returns 0x1C with bit 0 equal to the full flag (0x1D when the buffer is full, 0x1C when it is empty).
- R3: A keyboard byte that is accepted fills the buffer. irq goes high in the next cycle only if bit 0 of the configuration byte is 1 at that time. A byte loaded by command 0x20 follows the same interrupt rule.
- R4: A read with host_port_cmd=0 returns the buffer byte. From the next cycle the full flag and irq are 0.
- R5: Command 0x20 places the configuration byte into the buffer and sets the full flag.
- R6: After command 0x60, the next data-port write replaces the configuration byte. This write does not fill the buffer.
- R7: After command 0xD1, the next data-port write sets a20_gate to 1 for 0xDF and to 0 for 0xDD, and leaves it unchanged for any other value. That write also empties the buffer and withdraws irq. a20_gate changes at no other time.
- R8: Command 0xAD raises kbd_hold and command 0xAE releases it. While the keyboard is switched off, keyboard loads are dropped.
- R9: kbd_hold is also high while the buffer is full. A keyboard load while the buffer is full is dropped, and the first byte is kept.
- R10: Any command 0xF0 to 0xFF empties the buffer, withdraws irq and cancels a pending write. An even code drives cpu_reset high for exactly PULSE_CYCLES cycles, starting the cycle after the write. An odd code produces no pulse.
- R11: An even 0xF0 to 0xFF command received during a pulse restarts the count, so cpu_reset stays high for PULSE_CYCLES cycles after the second command.
- R12: Unrecognised command codes, and data-port writes with no pending command, change no state.
- R13: When command 0x20 and a keyboard load occur in the same cycle, the configuration byte is loaded and the keyboard byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle, never together with host_rd |
| host_port_cmd | input | 1 | 1 selects the command/status port, 0 selects the data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte: status or buffer, depending on host_port_cmd |
| kbd_load | input | 1 | Keyboard side offers a byte |
| kbd_byte | input | 8 | Byte offered by the keyboard side |
| kbd_hold | output | 1 | Keyboard side must hold off; loads are dropped while high |
| irq | output | 1 | Interrupt request for buffered data |
| a20_gate | output | 1 | Address line 20 gate |
| cpu_reset | output | 1 | CPU reset pulse, active high |

## Verification
The bench targets the following corner cases:
- Interrupt gating. A configuration byte with bit 0 cleared must still let a byte fill the buffer while irq stays low. A design that gated the load instead of the interrupt would lose the byte.
- A second keyboard byte offered while the buffer is full, and a keyboard byte offered in the same cycle as command 0x20. A design with the wrong priority would overwrite the first byte or the configuration copy.
- Pulse timing. The pulse width is measured in cycles, odd codes must give no pulse, and a restart during a pulse must extend it to the full width. An off-by-one counter or a missing reload shows up as a wrong width.
- Output-port values other than 0xDF and 0xDD, unknown commands, and stray data writes must leave a20_gate and the configuration byte untouched.

// File: rtl/kbc_pkg.sv
// Shared constants and types for the keyboard controller host interface.
// Assumes byte-wide host accesses; all command codes are 8 bits.
package kbc_pkg;

    localparam int BYTE_W = 8;

    // Command codes seen on the command port
    localparam logic [BYTE_W-1:0] OP_READ_CFG  = 8'h20;
    localparam logic [BYTE_W-1:0] OP_WRITE_CFG = 8'h60;
    localparam logic [BYTE_W-1:0] OP_WRITE_OUT = 8'hD1;
    localparam logic [BYTE_W-1:0] OP_KBD_OFF   = 8'hAD;
    localparam logic [BYTE_W-1:0] OP_KBD_ON    = 8'hAE;
    localparam logic [3:0]        OP_PULSE_HI  = 4'hF;

    // Output-port values that move the address-line-20 gate
    localparam logic [BYTE_W-1:0] OUT_GATE_ON  = 8'hDF;
    localparam logic [BYTE_W-1:0] OUT_GATE_OFF = 8'hDD;

    // Status byte fixed bits and configuration reset value
    localparam logic [BYTE_W-1:0] STATUS_BASE  = 8'h1C;
    localparam logic [BYTE_W-1:0] CFG_RESET    = 8'h01;

    // Destination of the next data-port write
    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_CFG  = 2'd1,
        DST_OUT  = 2'd2
    } dest_e;

    // One flag per recognised command group
    typedef struct packed {
        logic read_cfg;
        logic write_cfg;
        logic write_out;
        logic kbd_off;
        logic kbd_on;
        logic pulse_grp;
        logic pulse_fire;
    } cmd_dec_t;

endpackage

// File: rtl/kbc_cmd_decode.sv
// Command decoder: turns a command-port byte into group flags.
// Assumes the caller qualifies the flags with the write strobe.
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  logic [BYTE_W-1:0] code,
    output cmd_dec_t          dec
);

    // Purpose: compare the code against each recognised command
    always_comb begin
        dec            = '0;
        dec.read_cfg   = (code == OP_READ_CFG);
        dec.write_cfg  = (code == OP_WRITE_CFG);
        dec.write_out  = (code == OP_WRITE_OUT);
        dec.kbd_off    = (code == OP_KBD_OFF);
        dec.kbd_on     = (code == OP_KBD_ON);
        dec.pulse_grp  = (code[BYTE_W-1:BYTE_W-4] == OP_PULSE_HI);
        dec.pulse_fire = dec.pulse_grp && !code[0];
    end

endmodule

// File: rtl/kbc_outbuf.sv
// One-byte output buffer with full flag and interrupt request.
// Priority: host load, then keyboard load, then clear. The caller
// guarantees that a keyboard load is only presented when accepted.
module kbc_outbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_load,
    input  logic [DW-1:0] host_byte,
    input  logic          kbd_load,
    input  logic [DW-1:0] kbd_byte,
    input  logic          irq_en,
    input  logic          clear,
    output logic [DW-1:0] buf_q,
    output logic          full_q,
    output logic          irq_q
);

    // Purpose: hold the buffered byte, its full flag and the interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            full_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (host_load) begin
            buf_q  <= host_byte;
            full_q <= 1'b1;
            irq_q  <= irq_en;
        end else if (kbd_load) begin
            buf_q  <= kbd_byte;
            full_q <= 1'b1;
            irq_q  <= irq_en;
        end else if (clear) begin
            full_q <= 1'b0;
            irq_q  <= 1'b0;
        end
    end

    // R3: interrupt is only ever raised for a full buffer
    a_r3_irq_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> full_q);

    // R4: a clear with no load empties the buffer and drops the request
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !host_load && !kbd_load) |=> (!full_q && !irq_q));

    // R13: a host load always wins over a keyboard load
    a_r13_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
        host_load |=> (buf_q == $past(host_byte)));

endmodule

// File: rtl/kbc_pulse_gen.sv
// Reset pulse generator: a start loads the count, high while non-zero.
// Assumes PULSE_CYCLES >= 1; a start during a pulse reloads the count.
module kbc_pulse_gen #(
    parameter int PULSE_CYCLES = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);

    localparam int CW = $clog2(PULSE_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Purpose: load or count down the remaining pulse cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(PULSE_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign pulse = (cnt_q != '0);

    // R10: a start drives the pulse high on the next cycle
    a_r10_start_fires: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pulse);

    // R10: without a start, an idle output stays idle
    a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && !start) |=> !pulse);

    // R11: a start mid-pulse reloads the full width
    a_r11_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (start && pulse) |=> (cnt_q == CW'(PULSE_CYCLES)));

endmodule

// File: rtl/kbc_host_if.sv
// Keyboard controller host interface: data port, command/status port,
// output buffer, configuration byte, pending-write destination, address
// gate and reset pulse. Assumes host_rd and host_wr never overlap.
module kbc_host_if
    import kbc_pkg::*;
#(
    parameter int PULSE_CYCLES = 300000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              host_port_cmd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              kbd_load,
    input  logic [BYTE_W-1:0] kbd_byte,
    output logic              kbd_hold,
    output logic              irq,
    output logic              a20_gate,
    output logic              cpu_reset
);

    cmd_dec_t          dec;
    dest_e             dest_q;
    logic [BYTE_W-1:0] cfg_q;
    logic              kbd_off_q;
    logic              a20_q;
    logic [BYTE_W-1:0] buf_q;
    logic              full_q;
    logic              irq_q;
    logic              cmd_wr, data_wr, data_rd;
    logic              host_load, kbd_accept, buf_clear, out_wr, cfg_wr;
    logic              known_cmd;

    // Purpose: qualify host strobes by port
    always_comb begin
        cmd_wr     = host_wr && host_port_cmd;
        data_wr    = host_wr && !host_port_cmd;
        data_rd    = host_rd && !host_port_cmd;
        out_wr     = data_wr && (dest_q == DST_OUT);
        cfg_wr     = data_wr && (dest_q == DST_CFG);
        host_load  = cmd_wr && dec.read_cfg;
        kbd_accept = kbd_load && !kbd_hold && !host_load;
        buf_clear  = data_rd || (cmd_wr && dec.pulse_grp) || out_wr;
        known_cmd  = dec.read_cfg || dec.write_cfg || dec.write_out ||
                     dec.kbd_off || dec.kbd_on || dec.pulse_grp;
    end

    kbc_cmd_decode u_dec (
        .code (host_wdata),
        .dec  (dec)
    );

    // Purpose: track where the next data-port write goes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q <= DST_NONE;
        end else if (cmd_wr) begin
            if (dec.write_cfg)      dest_q <= DST_CFG;
            else if (dec.write_out) dest_q <= DST_OUT;
            else if (dec.pulse_grp) dest_q <= DST_NONE;
        end else if (data_wr) begin
            dest_q <= DST_NONE;
        end
    end

    // Purpose: configuration byte, written only through a pending write
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= CFG_RESET;
        else if (cfg_wr) cfg_q <= host_wdata;
    end

    // Purpose: keyboard switch-off flag from the on/off commands
    always_ff @(posedge clk) begin
        if (!rst_n)                      kbd_off_q <= 1'b0;
        else if (cmd_wr && dec.kbd_off)  kbd_off_q <= 1'b1;
        else if (cmd_wr && dec.kbd_on)   kbd_off_q <= 1'b0;
    end

    // Purpose: address gate driven by the output-port write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a20_q <= 1'b0;
        end else if (out_wr) begin
            if (host_wdata == OUT_GATE_ON)       a20_q <= 1'b1;
            else if (host_wdata == OUT_GATE_OFF) a20_q <= 1'b0;
        end
    end

    kbc_outbuf #(.DW(BYTE_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_load (host_load),
        .host_byte (cfg_q),
        .kbd_load  (kbd_accept),
        .kbd_byte  (kbd_byte),
        .irq_en    (cfg_q[0]),
        .clear     (buf_clear),
        .buf_q     (buf_q),
        .full_q    (full_q),
        .irq_q     (irq_q)
    );

    kbc_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cmd_wr && dec.pulse_fire),
        .pulse (cpu_reset)
    );

    // Purpose: drive outputs and the read mux
    always_comb begin
        kbd_hold   = kbd_off_q || full_q;
        irq        = irq_q;
        a20_gate   = a20_q;
        host_rdata = host_port_cmd ? (STATUS_BASE | {{(BYTE_W-1){1'b0}}, full_q})
                                   : buf_q;
    end

    // R2: a pending interrupt is always visible in status bit 0
    a_r2_status_shows_data: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_port_cmd && irq) |-> host_rdata[0]);

    // R6: a configuration write never fills the buffer
    a_r6_cfg_write_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !kbd_accept) |=> (full_q == $past(full_q)));

    // R7: the gate moves only on an output-port write
    a_r7_gate_only_on_out: assert property (@(posedge clk) disable iff (!rst_n)
        !out_wr |=> $stable(a20_gate));

    // R8: while switched off, the buffer byte cannot change from the keyboard
    a_r8_off_drops_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_off_q && !host_load) |=> $stable(buf_q));

    // R12: unknown commands leave configuration and destination alone
    a_r12_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !known_cmd) |=> ($stable(cfg_q) && $stable(dest_q)));

endmodule

// File: tb/kbc_host_if_bench.sv
// Bench for kbc_host_if: a behavioural model advanced every clock and
// compared at every falling edge, plus directed checks per requirement.
module kbc_host_if_bench;

    localparam int P = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_port_cmd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       kbd_load = 1'b0;
    logic [7:0] kbd_byte = 8'h00;
    logic       kbd_hold, irq, a20_gate, cpu_reset;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;
    bit  cmp_on = 1'b0;

    // behavioural model state
    int m_cfg = 1, m_obuf = 0, m_full = 0, m_irq = 0;
    int m_a20 = 0, m_off = 0, m_dest = 0, m_cnt = 0;

    always #10 clk = ~clk;

    kbc_host_if #(.PULSE_CYCLES(P)) u_kbc_host_if (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_rd       (host_rd),
        .host_wr       (host_wr),
        .host_port_cmd (host_port_cmd),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .kbd_load      (kbd_load),
        .kbd_byte      (kbd_byte),
        .kbd_hold      (kbd_hold),
        .irq           (irq),
        .a20_gate      (a20_gate),
        .cpu_reset     (cpu_reset)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model advance on each rising edge
    always @(posedge clk) begin : model
        int hload, old_cfg, old_hold;
        if (!rst_n) begin
            m_cfg = 1; m_obuf = 0; m_full = 0; m_irq = 0;
            m_a20 = 0; m_off = 0; m_dest = 0; m_cnt = 0;
        end else begin
            old_cfg  = m_cfg;
            old_hold = m_off | m_full;
            hload    = 0;
            if (m_cnt > 0) m_cnt--;
            if (host_wr && host_port_cmd) begin
                if (host_wdata == 8'h20)      hload = 1;
                else if (host_wdata == 8'h60) m_dest = 1;
                else if (host_wdata == 8'hD1) m_dest = 2;
                else if (host_wdata == 8'hAD) m_off = 1;
                else if (host_wdata == 8'hAE) m_off = 0;
                else if (host_wdata >= 8'hF0) begin
                    m_dest = 0; m_full = 0; m_irq = 0;
                    if (host_wdata[0] == 1'b0) m_cnt = P;
                end
            end else if (host_wr) begin
                if (m_dest == 1) m_cfg = host_wdata;
                else if (m_dest == 2) begin
                    if (host_wdata == 8'hDF) m_a20 = 1;
                    else if (host_wdata == 8'hDD) m_a20 = 0;
                    m_full = 0; m_irq = 0;
                end
                m_dest = 0;
            end
            if (host_rd && !host_port_cmd) begin
                m_full = 0; m_irq = 0;
            end
            if (hload != 0) begin
                m_obuf = old_cfg; m_full = 1; m_irq = old_cfg & 1;
            end else if (kbd_load && old_hold == 0) begin
                m_obuf = kbd_byte; m_full = 1; m_irq = old_cfg & 1;
            end
        end
    end

    // per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R3 irq vs model", irq, m_irq);
            chk("R10 cpu_reset vs model", cpu_reset, (m_cnt > 0) ? 1 : 0);
            chk("R7 a20_gate vs model", a20_gate, m_a20);
            chk("R8 R9 kbd_hold vs model", kbd_hold, m_off | m_full);
            if (host_rd)
                chk("R2 R4 host_rdata vs model", host_rdata,
                    host_port_cmd ? (32'h1C | m_full) : m_obuf);
        end
    end

    // all tasks start and end at rising edge + 4 ns with inputs idle
    task automatic cmd_wr(input logic [7:0] v);
        host_wr = 1'b1; host_port_cmd = 1'b1; host_wdata = v;
        @(posedge clk); #4;
        host_wr = 1'b0; host_port_cmd = 1'b0;
    endtask

    task automatic dat_wr(input logic [7:0] v);
        host_wr = 1'b1; host_port_cmd = 1'b0; host_wdata = v;
        @(posedge clk); #4;
        host_wr = 1'b0;
    endtask

    task automatic kbd(input logic [7:0] v);
        kbd_load = 1'b1; kbd_byte = v;
        @(posedge clk); #4;
        kbd_load = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        host_rd = 1'b1; host_port_cmd = sel;
        #6 d = host_rdata;
        @(posedge clk); #4;
        host_rd = 1'b0; host_port_cmd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #4; end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] d;
        int n;
        @(posedge clk); #4;
        idle(1);
        cmp_on = 1'b1;
        idle(1);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b1, d);
        chk("R1 status after reset", d, 8'h1C);
        chk("R1 irq after reset", irq, 0);
        chk("R1 cpu_reset after reset", cpu_reset, 0);
        chk("R1 a20_gate after reset", a20_gate, 0);
        chk("R1 kbd_hold after reset", kbd_hold, 0);
        cmd_wr(8'h20);
        chk("R5 buffer full after 0x20", kbd_hold, 1);
        chk("R3 irq raised with cfg bit0=1", irq, 1);
        rd(1'b0, d);
        chk("R1 reset configuration byte", d, 8'h01);
        chk("R4 irq withdrawn after read", irq, 0);

        // R2 R9 R4 keyboard bytes
        kbd(8'h5A);
        rd(1'b1, d);
        chk("R2 status with full buffer", d, 8'h1D);
        kbd(8'h77);
        rd(1'b0, d);
        chk("R9 first byte kept when full", d, 8'h5A);
        rd(1'b1, d);
        chk("R4 status empty after read", d, 8'h1C);

        // R6 configuration write, R3 gating
        cmd_wr(8'h60);
        dat_wr(8'h00);
        rd(1'b1, d);
        chk("R6 config write does not fill buffer", d, 8'h1C);
        kbd(8'h33);
        chk("R3 irq gated off by cfg bit0=0", irq, 0);
        chk("R3 byte still buffered", kbd_hold, 1);
        rd(1'b0, d);
        chk("R3 gated byte readable", d, 8'h33);
        cmd_wr(8'h20);
        rd(1'b0, d);
        chk("R6 config byte reads back 0x00", d, 8'h00);
        cmd_wr(8'h60);
        dat_wr(8'h45);
        cmd_wr(8'h20);
        chk("R5 irq from copied bit0=1", irq, 1);
        rd(1'b0, d);
        chk("R5 config byte reads back 0x45", d, 8'h45);
        cmd_wr(8'h60);
        dat_wr(8'h01);

        // R7 output port
        cmd_wr(8'hD1);
        dat_wr(8'hDF);
        chk("R7 gate on after 0xDF", a20_gate, 1);
        cmd_wr(8'hD1);
        dat_wr(8'h12);
        chk("R7 other value keeps gate", a20_gate, 1);
        kbd(8'h11);
        cmd_wr(8'hD1);
        dat_wr(8'hDD);
        chk("R7 gate off after 0xDD", a20_gate, 0);
        chk("R7 irq withdrawn by output write", irq, 0);
        rd(1'b1, d);
        chk("R7 output write empties buffer", d, 8'h1C);

        // R8 keyboard off/on
        cmd_wr(8'hAD);
        chk("R8 hold high when off", kbd_hold, 1);
        kbd(8'h44);
        rd(1'b1, d);
        chk("R8 load dropped while off", d, 8'h1C);
        cmd_wr(8'hAE);
        chk("R8 hold released", kbd_hold, 0);
        kbd(8'h44);
        rd(1'b0, d);
        chk("R8 load accepted after on", d, 8'h44);

        // R10 pulse width and buffer clear
        kbd(8'h22);
        cmd_wr(8'hFE);
        n = 0;
        while (cpu_reset && n < 4 * P) begin n++; idle(1); end
        chk("R10 pulse width", n, P);
        rd(1'b1, d);
        chk("R10 pulse command empties buffer", d, 8'h1C);
        kbd(8'h23);
        cmd_wr(8'hFF);
        chk("R10 odd code no pulse", cpu_reset, 0);
        chk("R10 odd code empties buffer", kbd_hold, 0);
        idle(2);
        chk("R10 still no pulse", cpu_reset, 0);

        // R11 restart
        cmd_wr(8'hFC);
        idle(3);
        cmd_wr(8'hFA);
        n = 0;
        while (cpu_reset && n < 4 * P) begin n++; idle(1); end
        chk("R11 restart gives full width", n, P);

        // R12 ignored writes
        cmd_wr(8'hA5);
        dat_wr(8'h99);
        rd(1'b1, d);
        chk("R12 status unchanged", d, 8'h1C);
        chk("R12 gate unchanged", a20_gate, 0);
        cmd_wr(8'h20);
        rd(1'b0, d);
        chk("R12 config byte unchanged", d, 8'h01);

        // R13 simultaneous host and keyboard load
        host_wr = 1'b1; host_port_cmd = 1'b1; host_wdata = 8'h20;
        kbd_load = 1'b1; kbd_byte = 8'h66;
        @(posedge clk); #4;
        host_wr = 1'b0; host_port_cmd = 1'b0; kbd_load = 1'b0;
        rd(1'b0, d);
        chk("R13 host load wins", d, 8'h01);
        rd(1'b1, d);
        chk("R13 keyboard byte dropped", d, 8'h1C);

        idle(2);
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

endmodule